// File: doc/BRIEF.md
# Activity Monitor Register Access Unit

This block holds four free-running 64-bit activity counters. Each counter's event number is fixed in hardware and reported through a read-only event-type register. The four counters track core clock cycles, ticks of a constant-rate timebase, retired instructions and cycles lost to memory stalls. Each counter has its own one-bit event input, and it advances by one on every clock in which that input is high.

Software reaches the counters and their type registers through a system-register port. Each request presents an encoded selector, the current privilege level (EL0 to EL3) and the control bits that govern access: the user enable, the hypervisor trap-general bit, the two activity-monitor trap controls, and the implemented/64-bit status of the higher levels. Before returning data, the block runs a fixed sequence of trap checks.

One cycle after each request, the block drives a valid strobe. With it comes either the register contents or a trap indication that carries an exception class and the privilege level that takes the trap. A configuration output reports how many counters are implemented.

Top module: `amu_access_top`

## Requirements
- R1: A selector hits when op0=2'b11, op1=3'b011 and CRn=4'b1101. In that case CRm[3:1]=3'b011 selects the event-type group and CRm[3:1]=3'b010 selects the counter group, and the index is n={CRm[0],op2}. Any other selector gives rsp_hit=0, rsp_trap=0 and rsp_rdata=0.
- R2: A read of the event-type register for n=0,1,2,3 returns 64'h0011, 64'h4004, 64'h0008 and 64'h4005 respectively. Bits 63:16 are always zero.
- R3: A hitting access with n from 4 to 15, in either group, has rsp_hit=1 and returns zero data.
- R4: Counter n (0 to 3) increases by exactly one at each clock edge where ev_pulse[n] is 1 and holds otherwise. ev_pulse[1] is the constant-rate tick. A counter read returns the count as it stood before the request's clock edge.
- R5: A write (acc_write=1) returns zero data and changes neither the counters nor the event-type values. Traps still apply to writes.
- R6: At EL0 (acc_el=0), when ctl_el1_a64=1 and ctl_user_en=0, the access traps. The target is EL2 when ctl_el2_en, ctl_el2_a64 and ctl_tge are all 1, and EL1 otherwise.
- R7: At EL0 or EL1, when R6 does not trap, the access traps to EL2 if ctl_el2_en, ctl_el2_a64 and ctl_el2_tam are all 1.
- R8: At EL0, EL1 or EL2, when the earlier checks do not trap, the access traps to EL3 if ctl_el3_have, ctl_el3_a64 and ctl_el3_tam are all 1. An access at EL3 never traps.
- R9: Only the first matching check in the order R6, R7, R8 is reported. Without a trap, rsp_trap_el=0 and rsp_ec=0.
- R10: A trap drives rsp_ec=6'h18 and rsp_rdata=0. The encoding of rsp_trap_el is 1=EL1, 2=EL2, 3=EL3.
- R11: rsp_valid is 1 in the cycle after acc_req=1 and 0 in the cycle after acc_req=0. When rsp_valid=0, all other response outputs are zero.
- R12: cfg_num_cnt reads 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 4 | Per-counter event inputs; bit 1 is the constant-rate tick |
| acc_req | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Selector op0 |
| acc_op1 | input | 3 | Selector op1 |
| acc_crn | input | 4 | Selector CRn |
| acc_crm | input | 4 | Selector CRm |
| acc_op2 | input | 3 | Selector op2 |
| acc_el | input | 2 | Current privilege level |
| ctl_el1_a64 | input | 1 | EL1 runs 64-bit |
| ctl_el2_en | input | 1 | EL2 enabled |
| ctl_el2_a64 | input | 1 | EL2 runs 64-bit |
| ctl_el3_have | input | 1 | EL3 implemented |
| ctl_el3_a64 | input | 1 | EL3 runs 64-bit |
| ctl_tge | input | 1 | Hypervisor trap-general bit |
| ctl_user_en | input | 1 | EL0 access enable |
| ctl_el2_tam | input | 1 | EL2 activity-monitor trap control |
| ctl_el3_tam | input | 1 | EL3 activity-monitor trap control |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Selector matched |
| rsp_trap | output | 1 | Access trapped |
| rsp_trap_el | output | 2 | Trap target level |
| rsp_ec | output | 6 | Exception class |
| rsp_rdata | output | 64 | Read data |
| cfg_num_cnt | output | 5 | Number of counters |

## Verification
The assertions check several properties on every cycle: the one-cycle valid strobe, the exception class and zero data on every trap, the rule that a trap always targets a level above the requester, the absence of traps at EL3, and the step-by-one or hold behaviour of each counter. Other behaviours only show in the bench's scenarios, which compare every output against a behavioural model: the exact trap target chosen under overlapping controls, the fixed event numbers, selector decoding, zero reads for indices 4 to 15, and the fact that writes leave all state unchanged.

// File: rtl/amu_pkg.sv
package amu_pkg;

    localparam int NUM_ARCH_CNT = 4;
    localparam int CNT_W        = 64;
    localparam int DATA_W       = 64;
    localparam int EVT_W        = 16;
    localparam int IDX_W        = 4;
    localparam int CFG_W        = 5;

    localparam logic [5:0] EC_MON_TRAP = 6'h18;

    localparam logic [1:0] SEL_OP0 = 2'b11;
    localparam logic [2:0] SEL_OP1 = 3'b011;
    localparam logic [3:0] SEL_CRN = 4'b1101;
    localparam logic [2:0] CRM_HI_TYPE = 3'b011;
    localparam logic [2:0] CRM_HI_CNT  = 3'b010;

    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_TYPE = 2'd1,
        GRP_CNT  = 2'd2
    } grp_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sel_t;

    typedef struct packed {
        grp_e             grp;
        logic [IDX_W-1:0] idx;
    } sel_dec_t;

    typedef struct packed {
        logic el1_a64;
        logic el2_en;
        logic el2_a64;
        logic el3_have;
        logic el3_a64;
        logic tge;
        logic user_en;
        logic el2_tam;
        logic el3_tam;
    } trap_ctl_t;

    typedef struct packed {
        logic trap;
        lvl_e tgt;
    } trap_res_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              trap;
        lvl_e              trap_el;
        logic [5:0]        ec;
        logic [DATA_W-1:0] data;
    } rsp_t;

    function automatic logic [EVT_W-1:0] evt_number(input logic [IDX_W-1:0] idx);
        logic [EVT_W-1:0] v;
        case (idx)
            4'd0:    v = 16'h0011;
            4'd1:    v = 16'h4004;
            4'd2:    v = 16'h0008;
            4'd3:    v = 16'h4005;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/amu_sel_decode.sv
module amu_sel_decode
    import amu_pkg::*;
(
    input  sel_t     sel,
    output sel_dec_t dec
);
    logic space_ok;

    always_comb begin
        space_ok = (sel.op0 == SEL_OP0) && (sel.op1 == SEL_OP1) && (sel.crn == SEL_CRN);
        dec.idx  = {sel.crm[0], sel.op2};
        dec.grp  = GRP_NONE;
        if (space_ok) begin
            if (sel.crm[3:1] == CRM_HI_TYPE) begin
                dec.grp = GRP_TYPE;
            end else if (sel.crm[3:1] == CRM_HI_CNT) begin
                dec.grp = GRP_CNT;
            end
        end
    end
endmodule

// File: rtl/amu_trap_check.sv
module amu_trap_check
    import amu_pkg::*;
(
    input  lvl_e      lvl,
    input  trap_ctl_t ctl,
    output trap_res_t res
);
    logic user_block;
    logic el2_gate;
    logic el3_gate;
    logic below_el2;
    logic below_el3;

    always_comb begin
        user_block = (lvl == LVL0) && ctl.el1_a64 && !ctl.user_en;
        below_el2  = (lvl == LVL0) || (lvl == LVL1);
        below_el3  = (lvl != LVL3);
        el2_gate   = below_el2 && ctl.el2_en && ctl.el2_a64 && ctl.el2_tam;
        el3_gate   = below_el3 && ctl.el3_have && ctl.el3_a64 && ctl.el3_tam;

        res.trap = 1'b0;
        res.tgt  = LVL0;
        if (user_block) begin
            res.trap = 1'b1;
            res.tgt  = (ctl.el2_en && ctl.el2_a64 && ctl.tge) ? LVL2 : LVL1;
        end else if (el2_gate) begin
            res.trap = 1'b1;
            res.tgt  = LVL2;
        end else if (el3_gate) begin
            res.trap = 1'b1;
            res.tgt  = LVL3;
        end
    end
endmodule

// File: rtl/amu_counter_bank.sv
module amu_counter_bank #(
    parameter int NUM = 4,
    parameter int W   = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM-1:0]        inc,
    output logic [NUM-1:0][W-1:0] cnt
);
    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (inc[g]) begin
                cnt[g] <= cnt[g] + W'(1);
            end
        end
    end
endmodule

// File: rtl/amu_access_top.sv
module amu_access_top
    import amu_pkg::*;
#(
    parameter int NUM_CNT = NUM_ARCH_CNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] ev_pulse,
    input  logic               acc_req,
    input  logic               acc_write,
    input  logic [1:0]         acc_op0,
    input  logic [2:0]         acc_op1,
    input  logic [3:0]         acc_crn,
    input  logic [3:0]         acc_crm,
    input  logic [2:0]         acc_op2,
    input  logic [1:0]         acc_el,
    input  logic               ctl_el1_a64,
    input  logic               ctl_el2_en,
    input  logic               ctl_el2_a64,
    input  logic               ctl_el3_have,
    input  logic               ctl_el3_a64,
    input  logic               ctl_tge,
    input  logic               ctl_user_en,
    input  logic               ctl_el2_tam,
    input  logic               ctl_el3_tam,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_trap,
    output logic [1:0]         rsp_trap_el,
    output logic [5:0]         rsp_ec,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [CFG_W-1:0]   cfg_num_cnt
);
    localparam int CIDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    sel_t                         sel;
    sel_dec_t                     dec;
    trap_ctl_t                    tctl;
    trap_res_t                    tres;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    logic                         in_range;
    logic                         hit;
    logic                         take_trap;
    logic [DATA_W-1:0]            rd_data;
    rsp_t                         rsp_q;

    always_comb begin
        sel.op0 = acc_op0;
        sel.op1 = acc_op1;
        sel.crn = acc_crn;
        sel.crm = acc_crm;
        sel.op2 = acc_op2;

        tctl.el1_a64  = ctl_el1_a64;
        tctl.el2_en   = ctl_el2_en;
        tctl.el2_a64  = ctl_el2_a64;
        tctl.el3_have = ctl_el3_have;
        tctl.el3_a64  = ctl_el3_a64;
        tctl.tge      = ctl_tge;
        tctl.user_en  = ctl_user_en;
        tctl.el2_tam  = ctl_el2_tam;
        tctl.el3_tam  = ctl_el3_tam;
    end

    amu_sel_decode u_dec (
        .sel (sel),
        .dec (dec)
    );

    amu_trap_check u_trap (
        .lvl (lvl_e'(acc_el)),
        .ctl (tctl),
        .res (tres)
    );

    amu_counter_bank #(
        .NUM (NUM_CNT),
        .W   (CNT_W)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (ev_pulse),
        .cnt (cnt_q)
    );

    always_comb begin
        in_range  = (int'(dec.idx) < NUM_CNT);
        hit       = acc_req && (dec.grp != GRP_NONE);
        take_trap = hit && tres.trap;
        rd_data   = '0;
        if (in_range && !acc_write) begin
            if (dec.grp == GRP_TYPE) begin
                rd_data = {{(DATA_W-EVT_W){1'b0}}, evt_number(dec.idx)};
            end else if (dec.grp == GRP_CNT) begin
                rd_data = DATA_W'(cnt_q[dec.idx[CIDX_W-1:0]]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid   <= acc_req;
            rsp_q.hit     <= hit;
            rsp_q.trap    <= take_trap;
            rsp_q.trap_el <= take_trap ? tres.tgt : LVL0;
            rsp_q.ec      <= take_trap ? EC_MON_TRAP : 6'h00;
            rsp_q.data    <= (hit && !take_trap) ? rd_data : '0;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_hit     = rsp_q.hit;
    assign rsp_trap    = rsp_q.trap;
    assign rsp_trap_el = rsp_q.trap_el;
    assign rsp_ec      = rsp_q.ec;
    assign rsp_rdata   = rsp_q.data;
    assign cfg_num_cnt = CFG_W'(NUM_CNT);
endmodule

// File: rtl/amu_access_chk.sv
module amu_access_chk
    import amu_pkg::*;
#(
    parameter int NUM_CNT = NUM_ARCH_CNT
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_CNT-1:0]            ev_pulse,
    input logic                          acc_req,
    input logic [1:0]                    acc_el,
    input logic                          rsp_valid,
    input logic                          rsp_trap,
    input logic [1:0]                    rsp_trap_el,
    input logic [5:0]                    rsp_ec,
    input logic [DATA_W-1:0]             rsp_rdata,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        acc_req |=> rsp_valid); // R11
    AST_IDLE_AFTER_NOREQ: assert property (@(posedge clk) disable iff (rst)
        !acc_req |=> !rsp_valid); // R11
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (rsp_ec == 6'h18)); // R10
    AST_TRAP_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (rsp_rdata == '0)); // R10
    AST_TOP_LEVEL_FREE: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_el == 2'd3) |=> !rsp_trap); // R8
    AST_TRAP_GOES_UP: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_el != 2'd3) |=> (!rsp_trap || (rsp_trap_el > $past(acc_el)))); // R9

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt_chk
        AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
            ev_pulse[g] |=> (cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1))); // R4
        AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
            !ev_pulse[g] |=> $stable(cnt_q[g])); // R4
    end
endmodule

bind amu_access_top amu_access_chk #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_pulse    (ev_pulse),
    .acc_req     (acc_req),
    .acc_el      (acc_el),
    .rsp_valid   (rsp_valid),
    .rsp_trap    (rsp_trap),
    .rsp_trap_el (rsp_trap_el),
    .rsp_ec      (rsp_ec),
    .rsp_rdata   (rsp_rdata),
    .cnt_q       (cnt_q)
);

// File: tb/tb_amu_access_top.sv
module tb_amu_access_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ev_pulse = '0;
    logic        acc_req = 1'b0, acc_write = 1'b0;
    logic [1:0]  acc_op0 = '0;
    logic [2:0]  acc_op1 = '0;
    logic [3:0]  acc_crn = '0, acc_crm = '0;
    logic [2:0]  acc_op2 = '0;
    logic [1:0]  acc_el = '0;
    logic ctl_el1_a64 = 0, ctl_el2_en = 0, ctl_el2_a64 = 0, ctl_el3_have = 0;
    logic ctl_el3_a64 = 0, ctl_tge = 0, ctl_user_en = 1, ctl_el2_tam = 0, ctl_el3_tam = 0;
    logic        rsp_valid, rsp_hit, rsp_trap;
    logic [1:0]  rsp_trap_el;
    logic [5:0]  rsp_ec;
    logic [63:0] rsp_rdata;
    logic [4:0]  cfg_num_cnt;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R11";

    longint unsigned mcnt [4] = '{0, 0, 0, 0};
    logic [15:0] evt_tab [4] = '{16'h0011, 16'h4004, 16'h0008, 16'h4005};

    logic        e_valid, e_hit, e_trap;
    logic [1:0]  e_el;
    logic [5:0]  e_ec;
    logic [63:0] e_data;

    always #5 clk = ~clk;

    amu_access_top dut (
        .clk(clk), .rst(rst), .ev_pulse(ev_pulse),
        .acc_req(acc_req), .acc_write(acc_write),
        .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn),
        .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_el(acc_el),
        .ctl_el1_a64(ctl_el1_a64), .ctl_el2_en(ctl_el2_en), .ctl_el2_a64(ctl_el2_a64),
        .ctl_el3_have(ctl_el3_have), .ctl_el3_a64(ctl_el3_a64), .ctl_tge(ctl_tge),
        .ctl_user_en(ctl_user_en), .ctl_el2_tam(ctl_el2_tam), .ctl_el3_tam(ctl_el3_tam),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_trap(rsp_trap),
        .rsp_trap_el(rsp_trap_el), .rsp_ec(rsp_ec), .rsp_rdata(rsp_rdata),
        .cfg_num_cnt(cfg_num_cnt)
    );

    task automatic predict();
        int n;
        bit sel_ok;
        e_valid = 0; e_hit = 0; e_trap = 0; e_el = 0; e_ec = 0; e_data = 0;
        if (rst || !acc_req) return;
        e_valid = 1;
        sel_ok = (acc_op0 == 2'b11) && (acc_op1 == 3'b011) && (acc_crn == 4'b1101) &&
                 (acc_crm[3:1] == 3'b011 || acc_crm[3:1] == 3'b010);
        if (!sel_ok) return;
        e_hit = 1;
        n = {acc_crm[0], acc_op2};
        if (acc_el == 0 && ctl_el1_a64 && !ctl_user_en) begin
            e_trap = 1;
            e_el = (ctl_el2_en && ctl_el2_a64 && ctl_tge) ? 2 : 1;
        end else if (acc_el <= 1 && ctl_el2_en && ctl_el2_a64 && ctl_el2_tam) begin
            e_trap = 1; e_el = 2;
        end else if (acc_el <= 2 && ctl_el3_have && ctl_el3_a64 && ctl_el3_tam) begin
            e_trap = 1; e_el = 3;
        end
        if (e_trap) begin
            e_ec = 6'h18;
            return;
        end
        if (acc_write || n >= 4) return;
        if (acc_crm[3:1] == 3'b011) e_data = {48'h0, evt_tab[n]};
        else e_data = mcnt[n];
    endtask

    task automatic step();
        predict();
        @(posedge clk);
        #2;
        for (int i = 0; i < 4; i++) begin
            if (rst) mcnt[i] = 0;
            else if (ev_pulse[i]) mcnt[i] = mcnt[i] + 1;
        end
        checks++;
        if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_trap !== e_trap ||
            rsp_trap_el !== e_el || rsp_ec !== e_ec || rsp_rdata !== e_data) begin
            failures++;
            $display("FAIL %s: got v=%0b h=%0b t=%0b el=%0d ec=%h d=%h exp v=%0b h=%0b t=%0b el=%0d ec=%h d=%h",
                     cur_tag, rsp_valid, rsp_hit, rsp_trap, rsp_trap_el, rsp_ec, rsp_rdata,
                     e_valid, e_hit, e_trap, e_el, e_ec, e_data);
        end
    endtask

    task automatic access(input bit grp_cnt, input int n, input bit wr, input logic [1:0] el);
        acc_req = 1; acc_write = wr; acc_el = el;
        acc_op0 = 2'b11; acc_op1 = 3'b011; acc_crn = 4'b1101;
        acc_crm = {grp_cnt ? 3'b010 : 3'b011, 1'(n >> 3)};
        acc_op2 = 3'(n);
        step();
        acc_req = 0; acc_write = 0;
    endtask

    task automatic set_ctl(input logic [8:0] v);
        {ctl_el1_a64, ctl_el2_en, ctl_el2_a64, ctl_el3_have, ctl_el3_a64,
         ctl_tge, ctl_user_en, ctl_el2_tam, ctl_el3_tam} = v;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        cur_tag = "R11 reset";
        acc_req = 1; ev_pulse = 4'hF;
        step(); step();
        rst = 0; acc_req = 0; ev_pulse = 0;
        step();

        cur_tag = "R12";
        checks++;
        if (cfg_num_cnt !== 5'd4) begin
            failures++;
            $display("FAIL R12: got %0d expected 4", cfg_num_cnt);
        end

        cur_tag = "R2 type values";
        for (int n = 0; n < 4; n++) access(0, n, 0, 2'd3);
        cur_tag = "R3 out-of-range index";
        for (int n = 4; n < 16; n++) begin
            access(0, n, 0, 2'd3);
            access(1, n, 0, 2'd3);
        end

        cur_tag = "R4 counters";
        for (int c = 0; c < 20; c++) begin
            ev_pulse = 4'(c % 16);
            step();
        end
        ev_pulse = 4'b0101;
        for (int n = 0; n < 4; n++) access(1, n, 0, 2'd2);
        ev_pulse = 0;
        for (int n = 0; n < 4; n++) access(1, n, 0, 2'd1);

        cur_tag = "R5 writes ignored";
        for (int n = 0; n < 4; n++) begin
            access(0, n, 1, 2'd3);
            access(1, n, 1, 2'd3);
        end
        for (int n = 0; n < 4; n++) begin
            access(0, n, 0, 2'd3);
            access(1, n, 0, 2'd3);
        end

        cur_tag = "R1 decode misses";
        acc_req = 1; acc_el = 3;
        acc_op0 = 2'b10; acc_op1 = 3'b011; acc_crn = 4'b1101; acc_crm = 4'b0110; acc_op2 = 0; step();
        acc_op0 = 2'b11; acc_op1 = 3'b010; step();
        acc_op1 = 3'b011; acc_crn = 4'b1100; step();
        acc_crn = 4'b1101; acc_crm = 4'b0100; step();
        acc_crm = 4'b1110; step();
        acc_req = 0;

        cur_tag = "R6 user enable trap";
        set_ctl(9'b1_0_0_0_0_0_0_0_0); access(0, 0, 0, 2'd0);
        set_ctl(9'b1_1_1_0_0_1_0_0_0); access(0, 1, 0, 2'd0);
        set_ctl(9'b1_1_0_0_0_1_0_0_0); access(0, 1, 0, 2'd0);
        set_ctl(9'b0_0_0_0_0_0_0_0_0); access(0, 2, 0, 2'd0);

        cur_tag = "R7 EL2 trap control";
        set_ctl(9'b1_1_1_0_0_0_1_1_0); access(0, 0, 0, 2'd0); access(0, 0, 0, 2'd1);
        access(0, 0, 0, 2'd2);
        set_ctl(9'b1_0_1_0_0_0_1_1_0); access(0, 0, 0, 2'd1);

        cur_tag = "R8 EL3 trap control";
        set_ctl(9'b1_0_0_1_1_0_1_0_1);
        for (int e = 0; e < 4; e++) access(1, 0, 0, 2'(e));
        set_ctl(9'b1_0_0_1_0_0_1_0_1); access(1, 0, 0, 2'd1);

        cur_tag = "R9 R10 priority";
        set_ctl(9'b1_1_1_1_1_1_0_1_1); access(0, 0, 0, 2'd0);
        set_ctl(9'b1_1_1_1_1_0_0_1_1); access(0, 0, 0, 2'd0);
        set_ctl(9'b1_1_1_1_1_0_1_1_1); access(0, 0, 0, 2'd0); access(0, 0, 0, 2'd2);
        access(1, 3, 1, 2'd3);

        cur_tag = "R1 R9 random";
        for (int i = 0; i < 600; i++) begin
            ev_pulse = 4'($urandom);
            acc_req = 1'($urandom);
            acc_write = ($urandom % 4) == 0;
            acc_el = 2'($urandom);
            set_ctl(9'($urandom));
            acc_op0 = ($urandom % 8 == 0) ? 2'($urandom) : 2'b11;
            acc_op1 = ($urandom % 8 == 0) ? 3'($urandom) : 3'b011;
            acc_crn = ($urandom % 8 == 0) ? 4'($urandom) : 4'b1101;
            acc_crm = {($urandom % 6 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'b010 : 3'b011),
                       ($urandom % 4 == 0)};
            acc_op2 = 3'($urandom);
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule